// File: doc/BRIEF.md
# Framebuffer Pixel Unpacker

This block sits between a framebuffer word fetcher and a palette or colour stage. It takes a stream of 32-bit words for one display line and splits each word into pixels. Each pixel comes out in the low bits of a 32-bit output. For depths of 8 bits or less the pixel is a palette index. For 16 and 32 bits per pixel it is a direct colour. A control word selects the depth, the order in which pixels are taken from a word, and an optional red/blue channel swap. From the same control word and the line width, the block also reports how many framebuffer bytes one line occupies.

A line begins with a one-cycle start pulse. After that the unit accepts words through a valid/ready handshake and hands out pixels through a second valid/ready handshake. When the configured number of pixels has been delivered, it raises a done flag and stops. Any pixels left over in the last word are dropped.

Top module: `fb_pixel_unpacker`

## Requirements
- R1: The depth field `ctrl_i[3:1]` selects the pixel width. Codes 0, 1, 2, 3, 4 and 5 give 1, 2, 4, 8, 16 and 32 bits per pixel. Codes 6 and 7 behave as 8 bits. Each pixel appears zero-extended on `pix_data_o`.
- R2: `line_bytes_o` equals the line pixel count shifted right by 3, 2 or 1 at 1, 2 or 4 bits per pixel. It equals the pixel count at 8 bits. It equals the pixel count shifted left by 1 or 2 at 16 or 32 bits.
- R3: With `ctrl_i[10:9]` both clear, pixels leave each word starting from the least significant one. Slot k occupies bits `[k*bpp +: bpp]`.
- R4: With `ctrl_i[9]` set, pixels leave each word starting from the most significant slot, so slot order is fully reversed.
- R5: With only `ctrl_i[10]` set, bytes are visited from byte 0 upward. Within each byte the most significant pixel leaves first. Depths of 8 bits or more are unaffected.
- R6: When `ctrl_i[9]` and `ctrl_i[10]` are both set, the R4 ordering applies.
- R7: With `ctrl_i[8]` set, the red and blue fields are exchanged. At 16 bits these are bits [4:0] and [15:11]. At 32 bits these are bits [7:0] and [23:16]. Palette indices are never altered.
- R8: Unless `ctrl_i[0]` and `ctrl_i[11]` are both set, `pix_valid_o` and `word_ready_o` stay low.
- R9: `line_start_i` restarts the line. After exactly `line_px_i` pixels have been delivered, `line_done_o` is high from the next cycle. From then on no pixel is offered and no word is taken. A width of zero raises `line_done_o` straight after the start pulse. A line consumes exactly ceil(`line_px_i` / pixels-per-word) words.
- R10: While `pix_valid_o` is high and `pix_ready_i` is low, the offered pixel is held unchanged. No new word is taken while a loaded word still has pixels to give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 12 | Control word: enable, depth, swap, ordering, power |
| line_px_i | input | CNT_W | Pixels in one line |
| line_start_i | input | 1 | One-cycle pulse that opens a new line |
| word_valid_i | input | 1 | Fetched word available |
| word_data_i | input | 32 | Fetched framebuffer word |
| word_ready_o | output | 1 | Unit takes the word this cycle |
| pix_valid_o | output | 1 | Pixel available |
| pix_data_o | output | 32 | Pixel value, zero-extended |
| pix_ready_i | input | 1 | Downstream takes the pixel |
| line_bytes_o | output | CNT_W+2 | Bytes per line for the current depth |
| line_done_o | output | 1 | Line finished |

## Verification
Every depth is run under each of the three orderings, with the two big-endian bits set together as well. Random words are used for these runs. Sub-byte depths tell slot reversal over the whole word apart from reversal inside each byte. At 8 bits and above, the reversal inside bytes must have no effect. The swap bit is tried at 16, 32 and 8 bits, which separates the two field layouts and confirms that palette indices pass through untouched. Random pixel and word backpressure, together with odd line widths, exercise stalls, partial final words and the zero-width line.

// File: rtl/fbu_pkg.sv
package fbu_pkg;

  localparam int WORD_W  = 32;
  localparam int SLOT_W  = 5;
  localparam int DEPTH_W = 3;

  typedef enum logic [1:0] {
    ORD_LE      = 2'd0,
    ORD_BE_BYTE = 2'd1,
    ORD_BE_PIX  = 2'd2
  } order_e;

  typedef struct packed {
    logic [DEPTH_W-1:0] depth;   // log2 of bits per pixel, 0..5
    order_e             order;
    logic               rb_swap;
    logic               enabled;
    logic [SLOT_W-1:0]  slots_m1; // pixels per word minus one
  } cfg_t;

  // Codes above 5 fall back to 8 bits per pixel.
  function automatic logic [DEPTH_W-1:0] norm_depth(input logic [DEPTH_W-1:0] code);
    return (code > 3'd5) ? 3'd3 : code;
  endfunction

  function automatic logic [SLOT_W-1:0] slots_m1(input logic [DEPTH_W-1:0] depth);
    logic [SLOT_W:0] n;
    n = 6'd32 >> depth;
    return SLOT_W'(n - 6'd1);
  endfunction

  // XOR mask applied to the running slot counter.
  function automatic logic [SLOT_W-1:0] order_mask(input logic [DEPTH_W-1:0] depth,
                                                   input order_e order);
    case (order)
      ORD_BE_BYTE: return slots_m1(depth);
      ORD_BE_PIX:  return (depth < 3'd3) ? (5'd7 >> depth) : 5'd0;
      default:     return 5'd0;
    endcase
  endfunction

  function automatic logic [31:0] line_bytes(input logic [31:0] px,
                                             input logic [DEPTH_W-1:0] depth);
    if (depth < 3'd3) return px >> (3'd3 - depth);
    else              return px << (depth - 3'd3);
  endfunction

  function automatic logic [WORD_W-1:0] take_slot(input logic [WORD_W-1:0] word,
                                                  input logic [DEPTH_W-1:0] depth,
                                                  input logic [SLOT_W-1:0] slot);
    logic [SLOT_W-1:0] pos;
    logic [WORD_W-1:0] mask;
    pos  = slot << depth;
    mask = (depth >= 3'd5) ? '1 : ((32'd1 << (6'd1 << depth)) - 32'd1);
    return (word >> pos) & mask;
  endfunction

  function automatic logic [WORD_W-1:0] rb_fix(input logic [WORD_W-1:0] pix,
                                               input logic [DEPTH_W-1:0] depth,
                                               input logic swap);
    if (swap && depth == 3'd4)
      return {16'd0, pix[4:0], pix[10:5], pix[15:11]};
    else if (swap && depth == 3'd5)
      return {pix[31:24], pix[7:0], pix[15:8], pix[23:16]};
    else
      return pix;
  endfunction

endpackage

// File: rtl/fbu_ctrl_decode.sv
module fbu_ctrl_decode
  import fbu_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic [11:0]      ctrl_i,
  input  logic [CNT_W-1:0] line_px_i,
  output cfg_t             cfg_o,
  output logic [CNT_W+1:0] line_bytes_o
);

  logic [DEPTH_W-1:0] depth;
  logic               unused_ctrl;

  assign depth       = norm_depth(ctrl_i[3:1]);
  assign unused_ctrl = ^ctrl_i[7:4];

  always_comb begin
    cfg_o.depth    = depth;
    cfg_o.enabled  = ctrl_i[0] & ctrl_i[11];
    cfg_o.rb_swap  = ctrl_i[8];
    cfg_o.slots_m1 = slots_m1(depth);
    if (ctrl_i[9])       cfg_o.order = ORD_BE_BYTE;
    else if (ctrl_i[10]) cfg_o.order = ORD_BE_PIX;
    else                 cfg_o.order = ORD_LE;
  end

  assign line_bytes_o = (CNT_W+2)'(line_bytes(32'(line_px_i), depth));

endmodule

// File: rtl/fbu_word_buf.sv
module fbu_word_buf
  import fbu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              accept_en_i,
  input  logic              line_last_i,
  input  logic              pix_fire_i,
  input  logic [SLOT_W-1:0] slots_m1_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_data_i,
  output logic              word_ready_o,
  output logic              have_word_o,
  output logic [WORD_W-1:0] word_o,
  output logic [SLOT_W-1:0] slot_o
);

  logic last_in_word;
  logic word_fire;
  logic drain_last;

  assign last_in_word = (slot_o == slots_m1_i);
  assign drain_last   = pix_fire_i & last_in_word;
  // Refill in the same cycle the last pixel leaves, unless that pixel ends the line.
  assign word_ready_o = accept_en_i & (~have_word_o | (drain_last & ~line_last_i));
  assign word_fire    = word_valid_i & word_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_word_o <= 1'b0;
      word_o      <= '0;
      slot_o      <= '0;
    end else if (flush_i) begin
      have_word_o <= 1'b0;
      slot_o      <= '0;
    end else if (word_fire) begin
      have_word_o <= 1'b1;
      word_o      <= word_data_i;
      slot_o      <= '0;
    end else if (drain_last) begin
      have_word_o <= 1'b0;
      slot_o      <= '0;
    end else if (pix_fire_i) begin
      slot_o      <= slot_o + 1'b1;
    end
  end

  // R10: a loaded word that is not being drained blocks any new word
  p_hold_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (have_word_o && !pix_fire_i) |-> !word_ready_o);

  // R9: a freshly taken word starts at its first slot
  p_load_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_fire && !flush_i) |=> (have_word_o && slot_o == '0));

endmodule

// File: rtl/fbu_pixel_select.sv
module fbu_pixel_select
  import fbu_pkg::*;
(
  input  cfg_t              cfg_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [WORD_W-1:0] pix_o
);

  logic [SLOT_W-1:0] phys_slot;
  logic [WORD_W-1:0] raw_pix;

  assign phys_slot = slot_i ^ order_mask(cfg_i.depth, cfg_i.order);
  assign raw_pix   = take_slot(word_i, cfg_i.depth, phys_slot);
  assign pix_o     = rb_fix(raw_pix, cfg_i.depth, cfg_i.rb_swap);

endmodule

// File: rtl/fb_pixel_unpacker.sv
module fb_pixel_unpacker
  import fbu_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [11:0]      ctrl_i,
  input  logic [CNT_W-1:0] line_px_i,
  input  logic             line_start_i,
  input  logic             word_valid_i,
  input  logic [31:0]      word_data_i,
  output logic             word_ready_o,
  output logic             pix_valid_o,
  output logic [31:0]      pix_data_o,
  input  logic             pix_ready_i,
  output logic [CNT_W+1:0] line_bytes_o,
  output logic             line_done_o
);

  cfg_t              cfg;
  logic              have_word;
  logic [WORD_W-1:0] cur_word;
  logic [SLOT_W-1:0] cur_slot;
  logic [CNT_W-1:0]  px_cnt;
  logic [CNT_W:0]    px_next;
  logic              line_open;
  logic              line_last;
  logic              pix_fire;
  logic              accept_en;

  fbu_ctrl_decode #(.CNT_W(CNT_W)) u_dec (
    .ctrl_i       (ctrl_i),
    .line_px_i    (line_px_i),
    .cfg_o        (cfg),
    .line_bytes_o (line_bytes_o)
  );

  assign accept_en   = cfg.enabled & line_open;
  assign px_next     = {1'b0, px_cnt} + 1'b1;
  assign line_last   = (px_next == {1'b0, line_px_i});
  assign pix_valid_o = accept_en & have_word;
  assign pix_fire    = pix_valid_o & pix_ready_i;

  fbu_word_buf u_buf (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (line_start_i),
    .accept_en_i  (accept_en),
    .line_last_i  (line_last),
    .pix_fire_i   (pix_fire),
    .slots_m1_i   (cfg.slots_m1),
    .word_valid_i (word_valid_i),
    .word_data_i  (word_data_i),
    .word_ready_o (word_ready_o),
    .have_word_o  (have_word),
    .word_o       (cur_word),
    .slot_o       (cur_slot)
  );

  fbu_pixel_select u_sel (
    .cfg_i  (cfg),
    .word_i (cur_word),
    .slot_i (cur_slot),
    .pix_o  (pix_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_cnt      <= '0;
      line_open   <= 1'b0;
      line_done_o <= 1'b0;
    end else if (line_start_i) begin
      px_cnt      <= '0;
      line_open   <= (line_px_i != '0);
      line_done_o <= (line_px_i == '0);
    end else if (pix_fire) begin
      px_cnt <= px_next[CNT_W-1:0];
      if (line_last) begin
        line_open   <= 1'b0;
        line_done_o <= 1'b1;
      end
    end
  end

  // R8: nothing moves unless enable and power are both set
  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_i[0] && ctrl_i[11]) |-> (!pix_valid_o && !word_ready_o));

  // R9: a finished line is quiet on both handshakes
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_done_o |-> (!pix_valid_o && !word_ready_o));

  // R9: done only rises after a delivered pixel or a start pulse
  p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_done_o) |-> ($past(pix_fire) || $past(line_start_i)));

  // R10: a stalled pixel stays offered and unchanged
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && !pix_ready_i && !line_start_i) |=>
      (!$stable(ctrl_i) || (pix_valid_o && $stable(pix_data_o))));

endmodule

// File: tb/fb_pixel_unpacker_test.sv
`timescale 1ns/1ps
module fb_pixel_unpacker_test;

  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [11:0]      ctrl_i = '0;
  logic [CNT_W-1:0] line_px_i = '0;
  logic             line_start_i = 1'b0;
  logic             word_valid_i = 1'b0;
  logic [31:0]      word_data_i = '0;
  logic             word_ready_o;
  logic             pix_valid_o;
  logic [31:0]      pix_data_o;
  logic             pix_ready_i = 1'b0;
  logic [CNT_W+1:0] line_bytes_o;
  logic             line_done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] words [0:63];

  fb_pixel_unpacker #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_i), .line_px_i(line_px_i),
    .line_start_i(line_start_i), .word_valid_i(word_valid_i),
    .word_data_i(word_data_i), .word_ready_o(word_ready_o),
    .pix_valid_o(pix_valid_o), .pix_data_o(pix_data_o),
    .pix_ready_i(pix_ready_i), .line_bytes_o(line_bytes_o),
    .line_done_o(line_done_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int eff_bpp(input logic [11:0] c);
    int d;
    d = int'(c[3:1]);
    if (d > 5) d = 3;
    return 1 << d;
  endfunction

  function automatic logic [31:0] exp_pix(input logic [31:0] w, input logic [11:0] c, input int k);
    int bpp, ppw, ppb, slot;
    logic [31:0] v, t;
    bpp = eff_bpp(c);
    ppw = 32 / bpp;
    ppb = (bpp < 8) ? 8 / bpp : 1;
    if (c[9])       slot = ppw - 1 - k;
    else if (c[10]) slot = (k / ppb) * ppb + (ppb - 1 - (k % ppb));
    else            slot = k;
    v = '0;
    for (int i = 0; i < bpp; i++) v[i] = w[slot * bpp + i];
    if (c[8] && bpp == 16) begin
      t = v;
      v[4:0]   = t[15:11];
      v[15:11] = t[4:0];
    end else if (c[8] && bpp == 32) begin
      t = v;
      v[7:0]   = t[23:16];
      v[23:16] = t[7:0];
    end
    return v;
  endfunction

  function automatic logic [11:0] mk(input int depth, input bit sw, input bit beb, input bit bep);
    logic [11:0] c;
    c = 12'h801;
    c[3:1] = 3'(depth);
    c[8] = sw; c[9] = beb; c[10] = bep;
    return c;
  endfunction

  task automatic start_line(input logic [11:0] c, input int npx);
    @(negedge clk);
    ctrl_i = c;
    line_px_i = CNT_W'(npx);
    word_valid_i = 1'b0;
    pix_ready_i = 1'b0;
    line_start_i = 1'b1;
    @(negedge clk);
    line_start_i = 1'b0;
  endtask

  task automatic run_line(input logic [11:0] c, input int npx, input string req);
    int ppw, pcnt, wcnt, cyc, nwords;
    bit stall;
    logic [31:0] stall_val, e;
    ppw = 32 / eff_bpp(c);
    for (int i = 0; i < 64; i++) words[i] = $urandom;
    start_line(c, npx);
    #1;
    check(line_bytes_o == (CNT_W+2)'((npx * eff_bpp(c)) / 8), "R2", "bytes per line",
          longint'(line_bytes_o), longint'((npx * eff_bpp(c)) / 8));
    pcnt = 0; wcnt = 0; cyc = 0; stall = 0; stall_val = '0;
    while (pcnt < npx && cyc < 3000) begin
      word_valid_i = ($urandom % 4) != 0;
      word_data_i  = (wcnt < 64) ? words[wcnt] : 32'd0;
      pix_ready_i  = ($urandom % 3) != 0;
      #1;
      if (stall) begin
        check(pix_valid_o && pix_data_o == stall_val, "R10", "stalled pixel held",
              longint'(pix_data_o), longint'(stall_val));
        stall = 0;
      end
      if (pix_valid_o) begin
        if (pix_ready_i) begin
          e = exp_pix(words[pcnt / ppw], c, pcnt % ppw);
          check(pix_data_o == e, req, "pixel value", longint'(pix_data_o), longint'(e));
          pcnt++;
        end else begin
          stall = 1;
          stall_val = pix_data_o;
        end
      end
      if (word_valid_i && word_ready_o) wcnt++;
      @(negedge clk);
      cyc++;
    end
    check(cyc < 3000, req, "line completes in time", cyc, 3000);
    word_valid_i = 1'b1;
    pix_ready_i  = 1'b1;
    #1;
    check(line_done_o == 1'b1, "R9", "done after last pixel", line_done_o, 1);
    check(!pix_valid_o && !word_ready_o, "R9", "quiet after done",
          {pix_valid_o, word_ready_o}, 0);
    nwords = (npx + ppw - 1) / ppw;
    check(wcnt == nwords, "R9", "words consumed", wcnt, nwords);
    word_valid_i = 1'b0;
    pix_ready_i  = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20250117));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ctrl_i = 12'h801;
    #1;
    check(!pix_valid_o && !word_ready_o && !line_done_o, "R9", "reset state",
          {pix_valid_o, word_ready_o, line_done_o}, 0);

    // R8: enable or power missing
    for (int g = 0; g < 2; g++) begin
      start_line(g == 0 ? 12'h007 : 12'h806, 8);
      word_valid_i = 1'b1;
      pix_ready_i  = 1'b1;
      word_data_i  = 32'hA5A5_5A5A;
      repeat (6) begin
        @(negedge clk); #1;
        check(!pix_valid_o && !word_ready_o, "R8", "gated when disabled",
              {pix_valid_o, word_ready_o}, 0);
      end
      word_valid_i = 1'b0;
    end

    // R9: zero-width line
    start_line(12'h807, 0);
    word_valid_i = 1'b1; pix_ready_i = 1'b1;
    #1;
    check(line_done_o && !pix_valid_o && !word_ready_o, "R9", "zero width line",
          {line_done_o, pix_valid_o, word_ready_o}, 4);
    word_valid_i = 1'b0;

    // Every depth under every ordering
    for (int d = 0; d < 6; d++) begin
      run_line(mk(d, 0, 0, 0), 37, "R3");
      run_line(mk(d, 0, 1, 0), 41, "R4");
      run_line(mk(d, 0, 0, 1), 29, "R5");
      run_line(mk(d, 0, 1, 1), 33, "R6");
    end

    // R7: channel swap at 16, 32 and 8 bits
    run_line(mk(4, 1, 0, 0), 20, "R7");
    run_line(mk(5, 1, 1, 0), 17, "R7");
    run_line(mk(3, 1, 0, 0), 23, "R7");

    // R1: reserved depth codes
    run_line(mk(6, 0, 0, 0), 19, "R1");
    run_line(mk(7, 0, 0, 1), 26, "R1");
    run_line(mk(0, 0, 0, 0), 64, "R1");
    run_line(mk(5, 0, 0, 0), 1, "R1");

    // Random configurations and widths
    for (int n = 0; n < 30; n++) begin
      run_line(mk(int'($urandom % 8), 1'($urandom), 1'($urandom), 1'($urandom)),
               1 + int'($urandom % 64), "R1");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule